// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host sends 12-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. The block samples the link with its own system clock. It decodes each complete word and acts on a two-stage register set. There is one staging register and one output register for each channel, plus a power-down flag and a general-purpose output pin. Each output register holds the 8-bit code for the analog converter that sits downstream.

A serial data output repeats the bits that were shifted in. Several devices can therefore share one select line in a chain, and each one executes the last whole word it holds when select rises. The edge of the serial clock on which this output changes can be chosen by command. Two level inputs shape the behaviour. An active-low hardware load pin makes the output registers follow the staging registers. A power-down-enable pin decides whether the shutdown command is obeyed.

Top module: `qdac_cmd_if`

## Requirements
- R1: After reset, all staging and output registers hold 0x00. `shdn` is 0, `upo` is 0 and `dout` is 0. The data-output phase is the falling-edge mode.
- R2: A word is 12 bits sent most significant bit first. Bits 11:10 are the channel address, bits 9:8 are the control code and bits 7:0 are the data. Address 0..3 selects channel A..D, and channel A sits at `dac_codes[7:0]`. Bits are taken on `sclk` rising edges while `cs_n` is low.
- R3: A word executes when `cs_n` rises, and only if the number of bits clocked in is a nonzero multiple of 12. The last 12 bits are then used. Any other count discards the frame.
- R4: Control 01 writes the data into the addressed staging register and leaves every output register unchanged.
- R5: Control 11 writes the addressed staging register and then copies all four staging registers, including the new value, into the output registers.
- R6: Control 00 with address 01 copies all staging registers into the output registers and clears `shdn`.
- R7: Control 00 with address 10 writes the data into all four output registers and clears `shdn`. The staging registers are unchanged, and data 0x00 clears every channel.
- R8: Control 00 with address 11 sets `shdn` only while `pde` is high. Otherwise it has no effect.
- R9: Control 10 with address 00 drives `upo` low, and address 01 drives it high. The output registers are untouched.
- R10: Control 00 with address 00 is a no-operation and changes no register.
- R11: Control 10 with address 10 selects falling-edge mode, and address 11 selects rising-edge mode. Both copy all staging registers into the output registers. `dout` shows the bit received 12 `sclk` rising edges earlier. It changes on each `sclk` falling edge in falling-edge mode. In rising-edge mode it changes on each rising edge, before the new bit is shifted in.
- R12: While `ldac_n` is low, the output registers follow the staging registers on every clock. This takes precedence over the load-all command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial bit clock |
| din | input | 1 | Serial data in |
| ldac_n | input | 1 | Hardware load, active low, level sensitive |
| pde | input | 1 | Enables the shutdown command when high |
| dout | output | 1 | Serial chain data out |
| dac_codes | output | 32 | Four output codes, channel D in the top byte |
| shdn | output | 1 | Shutdown status |
| upo | output | 1 | General-purpose output pin |

## Verification
A command that rewrites a staging register can execute in the same clock in which the hardware load level copies staging to output. Likewise, the load-all broadcast can meet the hardware load override. The bench holds `ldac_n` low across a load-staging command and across a broadcast. It then judges that the addressed output code takes the new staging value without any update command, and that the broadcast value never displaces the staging contents. A second coincidence is that a phase-select command also updates every output. The bench checks both the output codes and the `dout` bit sequence of the next chained frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int QD_ADDR_W = 2;
    localparam int QD_CTL_W  = 2;
    localparam int QD_DATA_W = 8;
    localparam int QD_WORD_W = QD_ADDR_W + QD_CTL_W + QD_DATA_W;
    localparam int QD_NUM_CH = 1 << QD_ADDR_W;

    typedef enum logic [QD_CTL_W-1:0] {
        CTL_SYS     = 2'b00,
        CTL_LOAD    = 2'b01,
        CTL_AUX     = 2'b10,
        CTL_LOADUPD = 2'b11
    } ctl_e;

    typedef struct packed {
        logic [QD_ADDR_W-1:0] addr;
        ctl_e                 ctl;
        logic [QD_DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic                 wr_in;
        logic                 upd_all;
        logic                 bcast;
        logic                 wake;
        logic                 sleep;
        logic                 upo_wr;
        logic                 upo_val;
        logic                 mode_wr;
        logic                 mode_val;
        logic [QD_ADDR_W-1:0] addr;
        logic [QD_DATA_W-1:0] data;
    } act_t;

    function automatic act_t decode_word(word_t w, logic pde_en);
        act_t a;
        a      = '0;
        a.addr = w.addr;
        a.data = w.data;
        unique case (w.ctl)
            CTL_LOAD: a.wr_in = 1'b1;
            CTL_LOADUPD: begin
                a.wr_in   = 1'b1;
                a.upd_all = 1'b1;
            end
            CTL_SYS: begin
                unique case (w.addr)
                    2'd0: ;
                    2'd1: begin
                        a.upd_all = 1'b1;
                        a.wake    = 1'b1;
                    end
                    2'd2: begin
                        a.bcast = 1'b1;
                        a.wake  = 1'b1;
                    end
                    default: a.sleep = pde_en;
                endcase
            end
            default: begin
                unique case (w.addr)
                    2'd0: a.upo_wr = 1'b1;
                    2'd1: begin
                        a.upo_wr  = 1'b1;
                        a.upo_val = 1'b1;
                    end
                    2'd2: begin
                        a.mode_wr = 1'b1;
                        a.upd_all = 1'b1;
                    end
                    default: begin
                        a.mode_wr  = 1'b1;
                        a.mode_val = 1'b1;
                        a.upd_all  = 1'b1;
                    end
                endcase
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx #(
    parameter int WORD_W = qdac_pkg::QD_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              dout_mode,
    output logic [WORD_W-1:0] word,
    output logic              word_vld,
    output logic              dout
);

    localparam int CNT_W = $clog2(WORD_W);

    logic              sclk_q, cs_q, seen;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sreg;
    logic              sclk_rise, sclk_fall, cs_rise, shift_en, dout_en;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = cs_n_s & ~cs_q;
    assign shift_en  = ~cs_n_s & sclk_rise;
    assign dout_en   = ~cs_n_s & (dout_mode ? sclk_rise : sclk_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            seen     <= 1'b0;
            cnt      <= '0;
            sreg     <= '0;
            word_vld <= 1'b0;
            dout     <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            cs_q     <= cs_n_s;
            word_vld <= cs_rise & seen & (cnt == '0);
            if (shift_en) begin
                sreg <= {sreg[WORD_W-2:0], din_s};
                cnt  <= (cnt == CNT_W'(WORD_W - 1)) ? '0 : cnt + 1'b1;
                seen <= 1'b1;
            end
            if (cs_rise) begin
                cnt  <= '0;
                seen <= 1'b0;
            end
            if (dout_en) dout <= sreg[WORD_W-1];
        end
    end

    assign word = sreg;

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> $stable(sreg)); // R2

    AST_EXEC_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> cs_n_s); // R3

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int NUM_CH = QD_NUM_CH,
    parameter int DATA_W = QD_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  act_t                     act,
    input  logic                     act_vld,
    input  logic                     ldac_lo,
    output logic [NUM_CH*DATA_W-1:0] dac_codes,
    output logic                     shdn,
    output logic                     upo,
    output logic                     dout_mode
);

    logic [NUM_CH-1:0][DATA_W-1:0] in_q, in_nxt, dac_q, dac_nxt;
    logic shdn_nxt;

    always_comb begin
        in_nxt = in_q;
        if (act_vld && act.wr_in) in_nxt[act.addr] = act.data;
    end

    always_comb begin
        dac_nxt = dac_q;
        if (ldac_lo || (act_vld && act.upd_all)) begin
            dac_nxt = in_nxt;
        end else if (act_vld && act.bcast) begin
            for (int i = 0; i < NUM_CH; i++) dac_nxt[i] = act.data;
        end
    end

    always_comb begin
        shdn_nxt = shdn;
        if (act_vld && act.wake)       shdn_nxt = 1'b0;
        else if (act_vld && act.sleep) shdn_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q      <= '0;
            dac_q     <= '0;
            shdn      <= 1'b0;
            upo       <= 1'b0;
            dout_mode <= 1'b0;
        end else begin
            in_q  <= in_nxt;
            dac_q <= dac_nxt;
            shdn  <= shdn_nxt;
            if (act_vld && act.upo_wr)  upo       <= act.upo_val;
            if (act_vld && act.mode_wr) dout_mode <= act.mode_val;
        end
    end

    assign dac_codes = dac_q;

    AST_LOADIN_HOLDS_DAC: assert property (@(posedge clk) disable iff (rst)
        (act_vld && act.wr_in && !act.upd_all && !ldac_lo) |=> $stable(dac_q)); // R4

    AST_WAKE_CLEARS_SHDN: assert property (@(posedge clk) disable iff (rst)
        (act_vld && act.wake) |=> !shdn); // R6

    AST_UPO_HOLDS_DAC: assert property (@(posedge clk) disable iff (rst)
        (act_vld && act.upo_wr && !ldac_lo) |=> $stable(dac_q)); // R9

    AST_LDAC_TRACKS: assert property (@(posedge clk) disable iff (rst)
        ldac_lo |=> (dac_q == in_q)); // R12

endmodule

// File: rtl/qdac_cmd_if.sv
module qdac_cmd_if
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        sclk,
    input  logic                        din,
    input  logic                        ldac_n,
    input  logic                        pde,
    output logic                        dout,
    output logic [QD_NUM_CH*QD_DATA_W-1:0] dac_codes,
    output logic                        shdn,
    output logic                        upo
);

    localparam int NPINS = 5;

    logic                 cs_s, sclk_s, din_s, ldac_s, pde_s;
    logic [QD_WORD_W-1:0] word;
    logic                 word_vld, dout_mode;
    act_t                 act;

    qdac_sync #(
        .W       (NPINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b10010)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, din, ldac_n, pde}),
        .q   ({cs_s, sclk_s, din_s, ldac_s, pde_s})
    );

    qdac_serial_rx #(
        .WORD_W (QD_WORD_W)
    ) rx_i (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (cs_s),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .dout_mode (dout_mode),
        .word      (word),
        .word_vld  (word_vld),
        .dout      (dout)
    );

    assign act = decode_word(word_t'(word), pde_s);

    qdac_regbank #(
        .NUM_CH (QD_NUM_CH),
        .DATA_W (QD_DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .act_vld   (word_vld),
        .ldac_lo   (~ldac_s),
        .dac_codes (dac_codes),
        .shdn      (shdn),
        .upo       (upo),
        .dout_mode (dout_mode)
    );

    AST_SHDN_NEEDS_PDE: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn) |-> $past(pde_s)); // R8

endmodule

// File: tb/qdac_cmd_if_tb.sv
module qdac_cmd_if_tb_top;

    localparam int HP = 6;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, pde = 1'b0;
    logic        dout, shdn, upo;
    logic [31:0] dac_codes;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic pre_rise [32];
    logic pre_fall [32];

    always #2 clk = ~clk;

    qdac_cmd_if dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .din (din),
        .ldac_n (ldac_n), .pde (pde), .dout (dout), .dac_codes (dac_codes),
        .shdn (shdn), .upo (upo)
    );

    function automatic logic [11:0] wd(logic [1:0] a, logic [1:0] c, logic [7:0] d);
        return {a, c, d};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bits(int n, logic [31:0] bits);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            din = bits[n-1-b];
            repeat (HP) @(negedge clk);
            pre_rise[b] = dout;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            pre_fall[b] = dout;
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send12(logic [11:0] w);
        send_bits(12, {20'b0, w});
    endtask

    task automatic chain_check(string tag, logic [11:0] w1, bit rising);
        logic [11:0] seen;
        send_bits(24, {8'b0, w1, wd(2'd0, 2'b00, 8'h3C)});
        for (int b = 12; b < 24; b++) seen[23-b] = rising ? pre_fall[b] : pre_rise[b];
        check(tag, {20'b0, seen}, {20'b0, w1});
    endtask

    task automatic t_reset();
        check("R1 dac reset", dac_codes, 32'h0);
        check("R1 flags reset", {29'b0, shdn, upo, dout}, 32'h0);
    endtask

    task automatic t_chain_default();
        chain_check("R1 R11 default falling-edge chain", 12'hACB, 1'b0);
        check("R10 R3 nop after chain", dac_codes, 32'h0);
    endtask

    task automatic t_load_input();
        send12(wd(2'd0, 2'b01, 8'h11));
        send12(wd(2'd1, 2'b01, 8'h22));
        send12(wd(2'd2, 2'b01, 8'h33));
        send12(wd(2'd3, 2'b01, 8'h44));
        check("R4 R2 load staging only", dac_codes, 32'h0);
    endtask

    task automatic t_sw_load();
        send12(wd(2'd1, 2'b00, 8'h00));
        check("R6 R2 software load", dac_codes, 32'h44332211);
    endtask

    task automatic t_load_update();
        send12(wd(2'd0, 2'b01, 8'h1A));
        check("R4 staging A held", dac_codes, 32'h44332211);
        send12(wd(2'd1, 2'b11, 8'h5B));
        check("R5 load and update all", dac_codes, 32'h44335B1A);
    endtask

    task automatic t_broadcast();
        send12(wd(2'd2, 2'b00, 8'h77));
        check("R7 broadcast", dac_codes, 32'h77777777);
        send12(wd(2'd1, 2'b00, 8'h00));
        check("R7 staging kept", dac_codes, 32'h44335B1A);
        send12(wd(2'd2, 2'b00, 8'h00));
        check("R7 clear all", dac_codes, 32'h0);
        send12(wd(2'd1, 2'b00, 8'h00));
    endtask

    task automatic t_shutdown();
        pde = 1'b0;
        send12(wd(2'd3, 2'b00, 8'h00));
        check("R8 shutdown ignored", {31'b0, shdn}, 32'h0);
        pde = 1'b1;
        send12(wd(2'd3, 2'b00, 8'h00));
        check("R8 shutdown taken", {31'b0, shdn}, 32'h1);
        check("R8 dac kept", dac_codes, 32'h44335B1A);
        send12(wd(2'd2, 2'b00, 8'h66));
        check("R7 broadcast wakes", {shdn, dac_codes[30:0]}, {1'b0, 31'h66666666 & 31'h7FFFFFFF});
        send12(wd(2'd3, 2'b00, 8'h00));
        send12(wd(2'd1, 2'b00, 8'h00));
        check("R6 load wakes", {31'b0, shdn}, 32'h0);
        check("R6 load restores", dac_codes, 32'h44335B1A);
        pde = 1'b0;
    endtask

    task automatic t_upo();
        send12(wd(2'd1, 2'b10, 8'hFF));
        check("R9 upo high", {31'b0, upo}, 32'h1);
        check("R9 dac untouched", dac_codes, 32'h44335B1A);
        send12(wd(2'd0, 2'b10, 8'hFF));
        check("R9 upo low", {31'b0, upo}, 32'h0);
    endtask

    task automatic t_nop();
        send12(wd(2'd0, 2'b00, 8'hFF));
        check("R10 nop", {shdn, upo, 30'b0} | {2'b0, 30'h0}, 32'h0);
        check("R10 nop dac", dac_codes, 32'h44335B1A);
    endtask

    task automatic t_discard();
        logic [11:0] w;
        w = wd(2'd0, 2'b11, 8'hEE);
        send_bits(11, {21'b0, w[11:1]});
        check("R3 eleven bits dropped", dac_codes, 32'h44335B1A);
        send_bits(13, {19'b0, 1'b1, w});
        check("R3 thirteen bits dropped", dac_codes, 32'h44335B1A);
        send_bits(24, {8'b0, wd(2'd1, 2'b11, 8'hBB), wd(2'd2, 2'b11, 8'hCC)});
        check("R3 double word runs last", dac_codes, 32'h44CC5B1A);
    endtask

    task automatic t_modes();
        send12(wd(2'd3, 2'b01, 8'h4D));
        send12(wd(2'd3, 2'b10, 8'h00));
        check("R11 rising mode updates", dac_codes, 32'h4DCC5B1A);
        chain_check("R11 rising-edge chain", 12'h5A3, 1'b1);
        send12(wd(2'd0, 2'b01, 8'hA0));
        send12(wd(2'd2, 2'b10, 8'h00));
        check("R11 falling mode updates", dac_codes, 32'h4DCC5BA0);
        chain_check("R11 falling-edge chain", 12'h9C6, 1'b0);
    endtask

    task automatic t_ldac();
        ldac_n = 1'b0;
        repeat (10) @(negedge clk);
        send12(wd(2'd2, 2'b01, 8'hC7));
        check("R12 follow staging", dac_codes, 32'h4DC75BA0);
        send12(wd(2'd2, 2'b00, 8'h11));
        check("R12 overrides broadcast", dac_codes, 32'h4DC75BA0);
        ldac_n = 1'b1;
        repeat (10) @(negedge clk);
        send12(wd(2'd2, 2'b01, 8'h0C));
        check("R4 after hardware load", dac_codes, 32'h4DC75BA0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_chain_default();
        t_load_input();
        t_sw_load();
        t_load_update();
        t_broadcast();
        t_shutdown();
        t_upo();
        t_nop();
        t_discard();
        t_modes();
        t_ldac();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule